// File: doc/BRIEF.md
# Processor Exception Vector and Fault-State Unit

This block sits beside a processor pipeline and turns a single fault request into a jump target and a set of system-control register updates. A request names the fault kind, whether the access was a store, the faulting virtual address, the address-space identifier, the virtual page number and a coprocessor number. From these, the block computes the five-bit exception code and the vector address. In the same clock edge it updates the register fields that this kind of fault affects.

The block holds six 32-bit system registers: Status, Cause, EBase, BadVAddr, EntryHi and Context. A one-cycle write port lets software load Status, Cause, EBase and Context. The vector base comes from one of two sources. When Status.BEV is set, it is a fixed boot address. Otherwise it is EBase. The offset depends on the fault kind, on Cause.IV and on the Status.EXL value that held before the fault.

Sequencing is a two-state machine. In S_IDLE, a request on fault_valid is accepted; this is the transition T_ACCEPT. Acceptance loads the vector and code registers, updates the system registers and moves the machine to S_RESPOND. In S_RESPOND, vector_valid is high for exactly one cycle and any request is dropped. The machine then returns to S_IDLE unconditionally; this is the transition T_RETIRE.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, Status reads 0x00400000 (BEV, bit 22, set; EXL, bit 1, clear), Cause reads 0, EBase reads 0x80000000, BadVAddr, EntryHi and Context read 0, and vector_valid is low.
- R2: The fault_kind encoding maps to exception codes as follows: 0 interrupt→0, 1 address error, 2 TLB refill, 3 TLB invalid, 4 TLB modified→1, 5 coprocessor unusable→11, 6 syscall→8, 7 breakpoint→9, 8 reserved opcode→10, 9 overflow→12, 10 trap→13, 11 machine check→24, 12 instruction bus error→6, 13 data bus error→7, 14 watch→23, 15 cache error→30.
- R3: vector_addr is the base plus the offset. The base is 0xBFC00200 when Status.BEV is 1 and EBase when it is 0.
- R4: An interrupt uses offset 0x200 when Cause.IV (bit 23) is 1, and 0x180 when it is 0.
- R5: A TLB refill uses offset 0x000 when Status.EXL was 0 before the fault, and 0x180 when it was 1. Every other kind except the interrupt uses 0x180.
- R6: An address error reports 5 on a store and 4 on a load. TLB refill and TLB invalid report 3 on a store and 2 on a load. A TLB modified fault reports 1 whatever fault_store is.
- R7: Address-error and TLB faults (kinds 1 to 4) copy fault_vaddr into BadVAddr. Every other kind leaves BadVAddr unchanged.
- R8: A TLB fault writes EntryHi as follows: fault_vpn shifted right by 2 into bits 31:14, fault_vpn bits 1:0 into bits 13:12, fault_asid into bits 7:0, and zero elsewhere.
- R9: A TLB fault writes fault_vpn shifted right by 2 into Context bits 21:4 and leaves every other Context bit unchanged.
- R10: A coprocessor-unusable fault writes fault_cop into Cause bits 29:28. Other kinds leave those bits unchanged.
- R11: Every accepted fault writes its code into Cause bits 6:2 and sets Status.EXL. The vector of that fault still uses the EXL value from before the fault.
- R12: A request accepted in S_IDLE raises vector_valid for exactly one cycle, beginning the cycle after acceptance, with vector_addr and exc_code valid. A request present while vector_valid is high is dropped and changes no register.
- R13: With csr_we high, csr_sel selects the target: 0 writes all of Status, 1 writes only Cause.IV, 2 writes EBase bits 31:12 (low 12 bits read 0), 3 writes all of Context. A fault accepted in the same cycle takes priority, and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | Fault request strobe |
| fault_kind | input | 4 | Fault kind encoding (R2) |
| fault_store | input | 1 | 1 for a store access, 0 for a load |
| fault_vaddr | input | 32 | Faulting virtual address |
| fault_asid | input | ASID_W | Address-space identifier |
| fault_vpn | input | VPN_W | Faulting virtual page number |
| fault_cop | input | 2 | Coprocessor number for coprocessor-unusable |
| csr_we | input | 1 | Software register write strobe |
| csr_sel | input | 2 | Write target select (R13) |
| csr_wdata | input | 32 | Software write data |
| vector_valid | output | 1 | One-cycle response strobe |
| vector_addr | output | 32 | Exception vector address |
| exc_code | output | 5 | Exception code of the last accepted fault |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| ebase_o | output | 32 | EBase register |
| badvaddr_o | output | 32 | BadVAddr register |
| entryhi_o | output | 32 | EntryHi register |
| context_o | output | 32 | Context register |

## Verification
A table walks every fault kind through the block. The rows vary the store flag, Cause.IV, Status.BEV and the prior Status.EXL, so that each row settles one of the following:
- a code-mapping entry;
- a store/load choice;
- a base selection;
- an offset rule.

The refill rows with EXL clear and with EXL set tell the two refill offsets apart. They also show that the vector uses the EXL value from before the fault. The interrupt rows with IV clear and with IV set tell the two interrupt offsets apart. Directed cases fill Context with ones before a TLB fault, so that any disturbance of the bits outside BadVPN2 shows up. They follow an address error with a syscall, to show that BadVAddr is written only by the kinds that own it. They present a request during the response cycle and a software write in the same cycle as a fault, to exercise the drop rule and the priority rule.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [3:0] {
        FK_INTR         = 4'd0,
        FK_ADDR         = 4'd1,
        FK_TLB_REFILL   = 4'd2,
        FK_TLB_INVALID  = 4'd3,
        FK_TLB_MOD      = 4'd4,
        FK_COP_UNUSABLE = 4'd5,
        FK_SYSCALL      = 4'd6,
        FK_BREAK        = 4'd7,
        FK_RESERVED_OP  = 4'd8,
        FK_OVERFLOW     = 4'd9,
        FK_TRAP         = 4'd10,
        FK_MCHECK       = 4'd11,
        FK_IFETCH_BUS   = 4'd12,
        FK_DATA_BUS     = 4'd13,
        FK_WATCH        = 4'd14,
        FK_CACHE_ERR    = 4'd15
    } fault_kind_e;

    typedef enum logic [1:0] {
        CSR_STATUS  = 2'd0,
        CSR_CAUSE   = 2'd1,
        CSR_EBASE   = 2'd2,
        CSR_CONTEXT = 2'd3
    } csr_sel_e;

    localparam int CODE_W = 5;

    localparam logic [CODE_W-1:0] EC_INT      = 5'd0;
    localparam logic [CODE_W-1:0] EC_TLB_MOD  = 5'd1;
    localparam logic [CODE_W-1:0] EC_TLB_LD   = 5'd2;
    localparam logic [CODE_W-1:0] EC_TLB_ST   = 5'd3;
    localparam logic [CODE_W-1:0] EC_ADR_LD   = 5'd4;
    localparam logic [CODE_W-1:0] EC_ADR_ST   = 5'd5;
    localparam logic [CODE_W-1:0] EC_IBUS     = 5'd6;
    localparam logic [CODE_W-1:0] EC_DBUS     = 5'd7;
    localparam logic [CODE_W-1:0] EC_SYSCALL  = 5'd8;
    localparam logic [CODE_W-1:0] EC_BREAK    = 5'd9;
    localparam logic [CODE_W-1:0] EC_RESV     = 5'd10;
    localparam logic [CODE_W-1:0] EC_COP      = 5'd11;
    localparam logic [CODE_W-1:0] EC_OVF      = 5'd12;
    localparam logic [CODE_W-1:0] EC_TRAP     = 5'd13;
    localparam logic [CODE_W-1:0] EC_WATCH    = 5'd23;
    localparam logic [CODE_W-1:0] EC_MCHECK   = 5'd24;
    localparam logic [CODE_W-1:0] EC_CACHE    = 5'd30;

    // Field positions that software and the vector logic both decode
    localparam int ST_BEV_BIT   = 22;
    localparam int ST_EXL_BIT   = 1;
    localparam int CA_IV_BIT    = 23;
    localparam int CA_CE_LSB    = 28;
    localparam int CA_CODE_LSB  = 2;
    localparam int CTX_VPN_LSB  = 4;

    localparam logic [31:0] BOOT_BASE   = 32'hBFC0_0200;
    localparam logic [31:0] OFF_GENERAL = 32'h0000_0180;
    localparam logic [31:0] OFF_INTVEC  = 32'h0000_0200;
    localparam logic [31:0] OFF_REFILL  = 32'h0000_0000;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  fault_kind_e        kind,
    input  logic               is_store,
    input  logic               cause_iv,
    input  logic               status_exl,
    input  logic               status_bev,
    input  logic [31:0]        ebase,
    output logic [CODE_W-1:0]  code,
    output logic [31:0]        vector,
    output logic               wr_badv,
    output logic               wr_tlb,
    output logic               wr_ce
);

    logic [31:0] offset;
    logic [31:0] base;

    always_comb begin
        code    = EC_INT;
        offset  = OFF_GENERAL;
        wr_badv = 1'b0;
        wr_tlb  = 1'b0;
        wr_ce   = 1'b0;
        unique case (kind)
            FK_INTR: begin
                code   = EC_INT;
                offset = cause_iv ? OFF_INTVEC : OFF_GENERAL;
            end
            FK_ADDR: begin
                code    = is_store ? EC_ADR_ST : EC_ADR_LD;
                wr_badv = 1'b1;
            end
            FK_TLB_REFILL: begin
                code    = is_store ? EC_TLB_ST : EC_TLB_LD;
                offset  = status_exl ? OFF_GENERAL : OFF_REFILL;
                wr_badv = 1'b1;
                wr_tlb  = 1'b1;
            end
            FK_TLB_INVALID: begin
                code    = is_store ? EC_TLB_ST : EC_TLB_LD;
                wr_badv = 1'b1;
                wr_tlb  = 1'b1;
            end
            FK_TLB_MOD: begin
                code    = EC_TLB_MOD;
                wr_badv = 1'b1;
                wr_tlb  = 1'b1;
            end
            FK_COP_UNUSABLE: begin
                code  = EC_COP;
                wr_ce = 1'b1;
            end
            FK_SYSCALL:     code = EC_SYSCALL;
            FK_BREAK:       code = EC_BREAK;
            FK_RESERVED_OP: code = EC_RESV;
            FK_OVERFLOW:    code = EC_OVF;
            FK_TRAP:        code = EC_TRAP;
            FK_MCHECK:      code = EC_MCHECK;
            FK_IFETCH_BUS:  code = EC_IBUS;
            FK_DATA_BUS:    code = EC_DBUS;
            FK_WATCH:       code = EC_WATCH;
            FK_CACHE_ERR:   code = EC_CACHE;
        endcase
    end

    assign base   = status_bev ? BOOT_BASE : ebase;
    assign vector = base + offset;

endmodule

// File: rtl/exc_resp_fsm.sv
module exc_resp_fsm #(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_valid,
    input  logic [AW-1:0] vec_in,
    input  logic [CW-1:0] code_in,
    output logic          accept,
    output logic          vector_valid,
    output logic [AW-1:0] vector_addr,
    output logic [CW-1:0] exc_code
);

    typedef enum logic {
        S_IDLE    = 1'b0,
        S_RESPOND = 1'b1
    } state_e;

    state_e state_q, state_d;

    // Transitions: T_ACCEPT (S_IDLE -> S_RESPOND), T_RETIRE (S_RESPOND -> S_IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    state_d = fault_valid ? S_RESPOND : S_IDLE;
            S_RESPOND: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign accept       = (state_q == S_IDLE) && fault_valid;
    assign vector_valid = (state_q == S_RESPOND);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector_addr <= '0;
            exc_code    <= '0;
        end else if (accept) begin
            vector_addr <= vec_in;
            exc_code    <= code_in;
        end
    end

    // R12: response lasts exactly one cycle
    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |=> !vector_valid);

    // R12: an idle request is answered on the next cycle
    p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !vector_valid) |=> vector_valid);

    // R12: a request during the response cycle is dropped
    p_drop_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (vector_valid && fault_valid) |=> (!vector_valid && $stable(exc_code)));

endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
    import exc_pkg::*;
#(
    parameter int          VPN_W     = 20,
    parameter int          ASID_W    = 8,
    parameter logic [31:0] EBASE_RST = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CODE_W-1:0] code,
    input  logic              wr_badv,
    input  logic              wr_tlb,
    input  logic              wr_ce,
    input  logic [31:0]       vaddr,
    input  logic [ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [1:0]        cop,
    input  logic              csr_we,
    input  csr_sel_e          csr_sel,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       status_q,
    output logic [31:0]       cause_q,
    output logic [31:0]       ebase_q,
    output logic [31:0]       badv_q,
    output logic [31:0]       entryhi_q,
    output logic [31:0]       context_q
);

    localparam int VPN2_W = VPN_W - 2;
    localparam int PAD_W  = 32 - VPN2_W - 2 - ASID_W;
    localparam logic [31:0] CTX_MASK = {{(32-VPN2_W){1'b0}}, {VPN2_W{1'b1}}} << CTX_VPN_LSB;

    logic [VPN2_W-1:0] vpn2;
    logic [1:0]        vpnx;

    assign vpn2 = vpn[VPN_W-1:2];
    assign vpnx = vpn[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= 32'h1 << ST_BEV_BIT;
            cause_q   <= '0;
            ebase_q   <= EBASE_RST;
            badv_q    <= '0;
            entryhi_q <= '0;
            context_q <= '0;
        end else if (accept) begin
            cause_q[CA_CODE_LSB +: CODE_W] <= code;
            status_q[ST_EXL_BIT]           <= 1'b1;
            if (wr_badv) badv_q <= vaddr;
            if (wr_tlb) begin
                entryhi_q                        <= {vpn2, vpnx, {PAD_W{1'b0}}, asid};
                context_q[CTX_VPN_LSB +: VPN2_W] <= vpn2;
            end
            if (wr_ce) cause_q[CA_CE_LSB +: 2] <= cop;
        end else if (csr_we) begin
            unique case (csr_sel)
                CSR_STATUS:  status_q            <= csr_wdata;
                CSR_CAUSE:   cause_q[CA_IV_BIT]  <= csr_wdata[CA_IV_BIT];
                CSR_EBASE:   ebase_q             <= {csr_wdata[31:12], 12'h000};
                CSR_CONTEXT: context_q           <= csr_wdata;
            endcase
        end
    end

    // R11: every accepted fault leaves EXL set
    p_exl_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> status_q[ST_EXL_BIT]);

    // R7: kinds that do not own BadVAddr leave it alone
    p_badv_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_badv) |=> $stable(badv_q));

    // R9: Context bits outside BadVPN2 survive a fault
    p_ctx_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((context_q & ~CTX_MASK) == $past(context_q & ~CTX_MASK)));

    // R13: a fault discards a same-cycle EBase write
    p_fault_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $stable(ebase_q));

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int          VPN_W     = 20,
    parameter int          ASID_W    = 8,
    parameter logic [31:0] EBASE_RST = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [3:0]        fault_kind,
    input  logic              fault_store,
    input  logic [31:0]       fault_vaddr,
    input  logic [ASID_W-1:0] fault_asid,
    input  logic [VPN_W-1:0]  fault_vpn,
    input  logic [1:0]        fault_cop,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [31:0]       csr_wdata,
    output logic              vector_valid,
    output logic [31:0]       vector_addr,
    output logic [4:0]        exc_code,
    output logic [31:0]       status_o,
    output logic [31:0]       cause_o,
    output logic [31:0]       ebase_o,
    output logic [31:0]       badvaddr_o,
    output logic [31:0]       entryhi_o,
    output logic [31:0]       context_o
);

    logic [CODE_W-1:0] cls_code;
    logic [31:0]       cls_vector;
    logic              cls_wr_badv, cls_wr_tlb, cls_wr_ce;
    logic              accept;

    exc_classify u_classify (
        .kind       (fault_kind_e'(fault_kind)),
        .is_store   (fault_store),
        .cause_iv   (cause_o[CA_IV_BIT]),
        .status_exl (status_o[ST_EXL_BIT]),
        .status_bev (status_o[ST_BEV_BIT]),
        .ebase      (ebase_o),
        .code       (cls_code),
        .vector     (cls_vector),
        .wr_badv    (cls_wr_badv),
        .wr_tlb     (cls_wr_tlb),
        .wr_ce      (cls_wr_ce)
    );

    exc_resp_fsm #(.AW(32), .CW(CODE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_valid  (fault_valid),
        .vec_in       (cls_vector),
        .code_in      (cls_code),
        .accept       (accept),
        .vector_valid (vector_valid),
        .vector_addr  (vector_addr),
        .exc_code     (exc_code)
    );

    exc_csr_file #(.VPN_W(VPN_W), .ASID_W(ASID_W), .EBASE_RST(EBASE_RST)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .code      (cls_code),
        .wr_badv   (cls_wr_badv),
        .wr_tlb    (cls_wr_tlb),
        .wr_ce     (cls_wr_ce),
        .vaddr     (fault_vaddr),
        .asid      (fault_asid),
        .vpn       (fault_vpn),
        .cop       (fault_cop),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel_e'(csr_sel)),
        .csr_wdata (csr_wdata),
        .status_q  (status_o),
        .cause_q   (cause_o),
        .ebase_q   (ebase_o),
        .badv_q    (badvaddr_o),
        .entryhi_q (entryhi_o),
        .context_q (context_o)
    );

endmodule

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EBASE_T = 32'h8000_4000;

    typedef struct packed {
        logic [3:0]  kind;
        logic        st;
        logic        iv;
        logic        bev;
        logic        exl;
        logic [4:0]  code;
        logic [31:0] off;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [0:NV-1] = '{
        '{4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  32'h180},
        '{4'd0,  1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  32'h200},
        '{4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 5'd0,  32'h200},
        '{4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 5'd4,  32'h180},
        '{4'd1,  1'b1, 1'b0, 1'b1, 1'b0, 5'd5,  32'h180},
        '{4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  32'h000},
        '{4'd2,  1'b1, 1'b0, 1'b0, 1'b1, 5'd3,  32'h180},
        '{4'd2,  1'b1, 1'b1, 1'b1, 1'b0, 5'd3,  32'h000},
        '{4'd3,  1'b0, 1'b0, 1'b0, 1'b1, 5'd2,  32'h180},
        '{4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 5'd3,  32'h180},
        '{4'd4,  1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  32'h180},
        '{4'd4,  1'b1, 1'b0, 1'b1, 1'b0, 5'd1,  32'h180},
        '{4'd5,  1'b0, 1'b1, 1'b0, 1'b0, 5'd11, 32'h180},
        '{4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 5'd8,  32'h180},
        '{4'd7,  1'b1, 1'b0, 1'b1, 1'b0, 5'd9,  32'h180},
        '{4'd8,  1'b0, 1'b0, 1'b0, 1'b1, 5'd10, 32'h180},
        '{4'd9,  1'b1, 1'b0, 1'b0, 1'b0, 5'd12, 32'h180},
        '{4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 5'd13, 32'h180},
        '{4'd11, 1'b0, 1'b0, 1'b1, 1'b0, 5'd24, 32'h180},
        '{4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 5'd6,  32'h180},
        '{4'd13, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7,  32'h180},
        '{4'd14, 1'b0, 1'b0, 1'b0, 1'b1, 5'd23, 32'h180},
        '{4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 5'd30, 32'h180}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic [3:0]  fault_kind = '0;
    logic        fault_store = 1'b0;
    logic [31:0] fault_vaddr = '0;
    logic [7:0]  fault_asid = '0;
    logic [19:0] fault_vpn = '0;
    logic [1:0]  fault_cop = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic        vector_valid;
    logic [31:0] vector_addr;
    logic [4:0]  exc_code;
    logic [31:0] status_o, cause_o, ebase_o, badvaddr_o, entryhi_o, context_o;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_unit u_dut (
        .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_kind(fault_kind),
        .fault_store(fault_store), .fault_vaddr(fault_vaddr), .fault_asid(fault_asid),
        .fault_vpn(fault_vpn), .fault_cop(fault_cop), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .vector_valid(vector_valid), .vector_addr(vector_addr),
        .exc_code(exc_code), .status_o(status_o), .cause_o(cause_o), .ebase_o(ebase_o),
        .badvaddr_o(badvaddr_o), .entryhi_o(entryhi_o), .context_o(context_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    // Leaves the bench at the negedge inside the response cycle
    task automatic do_fault(input logic [3:0] kind, input logic st, input logic [31:0] va,
                            input logic [7:0] asid, input logic [19:0] vpn, input logic [1:0] cop);
        @(negedge clk);
        fault_valid = 1'b1; fault_kind = kind; fault_store = st;
        fault_vaddr = va; fault_asid = asid; fault_vpn = vpn; fault_cop = cop;
        @(negedge clk);
        fault_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] exp_ctx, saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status_o, 32'h0040_0000);
        chk("R1 cause", cause_o, 32'h0);
        chk("R1 ebase", ebase_o, 32'h8000_0000);
        chk("R1 badvaddr", badvaddr_o, 32'h0);
        chk("R1 entryhi", entryhi_o, 32'h0);
        chk("R1 context", context_o, 32'h0);
        chk("R1 vector_valid", {31'b0, vector_valid}, 32'h0);

        // R13 software writes
        csr_write(2'd2, 32'h8000_4ABC);
        chk("R13 ebase low bits", ebase_o, EBASE_T);
        csr_write(2'd1, 32'hFFFF_FFFF);
        chk("R13 cause only IV", cause_o, 32'h0080_0000);
        csr_write(2'd1, 32'h0);
        csr_write(2'd0, 32'h1234_5678);
        chk("R13 status full", status_o, 32'h1234_5678);

        // Table walk: R2 R3 R4 R5 R6 R11
        for (int i = 0; i < NV; i++) begin
            csr_write(2'd0, {9'b0, TBL[i].bev, 20'b0, TBL[i].exl, 1'b0});
            csr_write(2'd1, {8'b0, TBL[i].iv, 23'b0});
            do_fault(TBL[i].kind, TBL[i].st, 32'h0000_1000 + i, 8'h00, 20'h00000, 2'd0);
            chk("R2/R6 code", {27'b0, exc_code}, {27'b0, TBL[i].code});
            chk("R3/R4/R5 vector", vector_addr,
                (TBL[i].bev ? 32'hBFC0_0200 : EBASE_T) + TBL[i].off);
            chk("R11 cause code", {27'b0, cause_o[6:2]}, {27'b0, TBL[i].code});
            chk("R11 exl set", {31'b0, status_o[1]}, 32'h1);
            chk("R12 valid pulse", {31'b0, vector_valid}, 32'h1);
            @(negedge clk);
            chk("R12 valid drop", {31'b0, vector_valid}, 32'h0);
        end

        // R7 BadVAddr ownership
        csr_write(2'd0, 32'h0);
        do_fault(4'd1, 1'b0, 32'hDEAD_0004, 8'h00, 20'h0, 2'd0);
        chk("R7 badvaddr written", badvaddr_o, 32'hDEAD_0004);
        do_fault(4'd6, 1'b0, 32'h1111_2222, 8'h00, 20'h0, 2'd0);
        chk("R7 badvaddr kept", badvaddr_o, 32'hDEAD_0004);

        // R8 R9 TLB state
        csr_write(2'd3, 32'hFFFF_FFFF);
        do_fault(4'd3, 1'b1, 32'h1234_5000, 8'h5A, 20'h12345, 2'd0);
        chk("R8 entryhi", entryhi_o, (32'(20'h12345 >> 2) << 14) | (32'h1 << 12) | 32'h5A);
        exp_ctx = (32'hFFFF_FFFF & ~(32'h3FFFF << 4)) | (32'(20'h12345 >> 2) << 4);
        chk("R9 context", context_o, exp_ctx);
        chk("R7 tlb badvaddr", badvaddr_o, 32'h1234_5000);

        // R10 coprocessor number
        do_fault(4'd5, 1'b0, 32'h0, 8'h0, 20'h0, 2'd2);
        chk("R10 cause CE", {30'b0, cause_o[29:28]}, 32'd2);
        do_fault(4'd6, 1'b0, 32'h0, 8'h0, 20'h0, 2'd3);
        chk("R10 CE kept", {30'b0, cause_o[29:28]}, 32'd2);

        // R12 request during response is dropped
        do_fault(4'd7, 1'b0, 32'h0, 8'h0, 20'h0, 2'd0);
        saved = badvaddr_o;
        fault_valid = 1'b1; fault_kind = 4'd1; fault_vaddr = 32'hCAFE_0000;
        @(negedge clk);
        fault_valid = 1'b0;
        chk("R12 busy drop valid", {31'b0, vector_valid}, 32'h0);
        chk("R12 busy drop badv", badvaddr_o, saved);
        chk("R12 busy drop code", {27'b0, exc_code}, 32'd9);

        // R13 fault wins over same-cycle write
        @(negedge clk);
        fault_valid = 1'b1; fault_kind = 4'd9; fault_store = 1'b0;
        csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = 32'h9000_0000;
        @(negedge clk);
        fault_valid = 1'b0; csr_we = 1'b0;
        chk("R13 ebase discarded", ebase_o, EBASE_T);
        chk("R13 fault code", {27'b0, exc_code}, 32'd12);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule